// File: doc/BRIEF.md
# Patterned Bresenham line draw engine

The block draws one straight line per start pulse. At the pulse it captures the configuration: start point, unsigned X and Y deltas, which axis is the major axis, a direction bit for each axis, a 16-bit on/off pattern with the index of its last used bit, a foreground and a background color, and a background-fill mode bit. It then walks the line one major-axis step at a time. An integer error accumulator decides when the minor axis moves.

Each step yields one line pixel. The pattern bit for that step decides the pixel's treatment. A set bit writes the pixel in the foreground color. A clear bit skips the pixel when background fill is off, or writes it in the background color when background fill is on. Written pixels leave the block on a valid/ready stream that carries X, Y and color. A one-cycle done pulse marks the end of the line. Address generation, pixel packing and blending belong to the blocks downstream.

Top module: `line_draw`

## Requirements
- R1: With major length L (the delta of the major axis) and minor delta m (m ≤ L), the line has exactly L+1 steps. Step 0 is the start point. Each later step moves the major coordinate by one. The error term starts at 2048 − floor(L/2). On each step the error gains m. When the result is 2048 or more, the minor coordinate also moves by one and L is subtracted from the error.
- R2: The direction bit of an axis selects the sense of its moves: 0 increments the coordinate and 1 decrements it. The major-axis select is 1 for X major and 0 for Y major.
- R3: Step k uses pattern bit number k mod (last+1), where `last` is the 4-bit last-bit index. The index advances on every step, whether the pixel is written or skipped. Bit 0 is used first.
- R4: A step whose pattern bit is 1 is emitted with the foreground color.
- R5: A step whose pattern bit is 0 is skipped (valid stays low) when background fill is 0. It is emitted with the background color when background fill is 1.
- R6: While valid is high and ready is low, the pixel is held with X, Y and color stable. The line does not advance.
- R7: Done is high for exactly one cycle, in the cycle after the last step is accepted or skipped. This holds even for a line with no written pixels.
- R8: The configuration is captured at the start pulse. A start pulse or a configuration change while a line is in progress has no effect on that line.
- R9: After reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| startX | input | 12 | Start X coordinate |
| startY | input | 12 | Start Y coordinate |
| deltaX | input | 11 | Absolute X distance |
| deltaY | input | 11 | Absolute Y distance |
| xMajor | input | 1 | 1: X is the major axis |
| xDec | input | 1 | 1: X decrements |
| yDec | input | 1 | 1: Y decrements |
| pattern | input | 16 | On/off pattern, bit 0 first |
| patLast | input | 4 | Index of the last pattern bit used |
| fgColor | input | 24 | Color of on pixels |
| bgColor | input | 24 | Color of off pixels in fill mode |
| bgFill | input | 1 | 1: off pixels painted, 0: skipped |
| pixReady | input | 1 | Downstream accepts the pixel |
| pixValid | output | 1 | Pixel present |
| pixX | output | 12 | Pixel X |
| pixY | output | 12 | Pixel Y |
| pixColor | output | 24 | Pixel color |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The bench targets lines whose pattern index must keep counting through skipped pixels. A design that froze the index on skips would shift the 8-on/8-off pattern out of phase with position. A short wrap length and an all-off pattern check the last-bit index and a line with no writes, where a wrong design would skip the wrap or never raise done. Stalls from a random ready signal, and a second start pulse with changed configuration during a stall, expose a design that drops, repeats or re-targets pixels. Zero-length, diagonal and decrementing Y-major lines check the endpoint count and the direction handling.

// File: rtl/line_pkg.sv
package line_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;
endpackage

// File: rtl/line_dp.sv
module line_dp
  import line_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DELTA_W = 11,
  parameter int COLOR_W = 24,
  parameter int PAT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strb,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [DELTA_W-1:0] deltaX,
  input  logic [DELTA_W-1:0] deltaY,
  input  logic               xMajor,
  input  logic               xDec,
  input  logic               yDec,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [$clog2(PAT_W)-1:0] patLast,
  input  logic [COLOR_W-1:0] fgColor,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               bgFill,
  output logic [COORD_W-1:0] curX,
  output logic [COORD_W-1:0] curY,
  output logic [COLOR_W-1:0] color,
  output logic               visible,
  output logic               lastPix
);
  localparam int CNT_W = $clog2(PAT_W);
  localparam int ERR_W = DELTA_W + 2;
  localparam logic signed [ERR_W-1:0] ERR_INIT = ERR_W'(2 ** DELTA_W);

  logic [DELTA_W-1:0] dMajR, dMinR, remain;
  logic [PAT_W-1:0]   patR;
  logic [CNT_W-1:0]   lastR, patIdx;
  logic [COLOR_W-1:0] fgR, bgR;
  logic               bgFillR, xMajorR, xDecR, yDecR;
  logic signed [ERR_W-1:0] err, errSum;
  logic               minorStep, onBit;
  logic [DELTA_W-1:0] majIn, minIn;

  assign majIn     = xMajor ? deltaX : deltaY;
  assign minIn     = xMajor ? deltaY : deltaX;
  assign errSum    = err + $signed({2'b00, dMinR});
  assign minorStep = errSum >= ERR_INIT;
  assign onBit     = patR[patIdx];
  assign visible   = onBit | bgFillR;
  assign color     = onBit ? fgR : bgR;
  assign lastPix   = remain == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curX <= '0; curY <= '0; err <= ERR_INIT; remain <= '0;
      dMajR <= '0; dMinR <= '0; patR <= '0; lastR <= '0; patIdx <= '0;
      fgR <= '0; bgR <= '0; bgFillR <= 1'b0;
      xMajorR <= 1'b1; xDecR <= 1'b0; yDecR <= 1'b0;
    end else if (strb.load) begin
      curX    <= startX;
      curY    <= startY;
      dMajR   <= majIn;
      dMinR   <= minIn;
      remain  <= majIn;
      err     <= ERR_INIT - $signed({3'b000, majIn[DELTA_W-1:1]});
      patR    <= pattern;
      lastR   <= patLast;
      patIdx  <= '0;
      fgR     <= fgColor;
      bgR     <= bgColor;
      bgFillR <= bgFill;
      xMajorR <= xMajor;
      xDecR   <= xDec;
      yDecR   <= yDec;
    end else if (strb.step) begin
      remain <= remain - 1'b1;
      patIdx <= (patIdx == lastR) ? '0 : patIdx + 1'b1;
      err    <= minorStep ? errSum - $signed({2'b00, dMajR}) : errSum;
      if (xMajorR || minorStep) curX <= xDecR ? curX - 1'b1 : curX + 1'b1;
      if (!xMajorR || minorStep) curY <= yDecR ? curY - 1'b1 : curY + 1'b1;
    end
  end

  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (err > 0) && (err <= ERR_INIT)); // R1
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    patIdx <= lastR); // R3
  AST_MAJOR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (xMajorR ? (curX != $past(curX)) : (curY != $past(curY)))); // R1
endmodule

// File: rtl/line_ctl.sv
module line_ctl
  import line_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        visible,
  input  logic        lastPix,
  input  logic        pixReady,
  output ctlStrobes_t strb,
  output logic        pixValid,
  output logic        done
);
  typedef enum logic {IDLE, RUN} state_t;
  state_t state;
  logic   adv;

  assign adv       = (state == RUN) && (!visible || pixReady);
  assign pixValid  = (state == RUN) && visible;
  assign strb.load = (state == IDLE) && start;
  assign strb.step = adv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      done  <= 1'b0;
    end else begin
      done <= adv && lastPix;
      if (strb.load) state <= RUN;
      else if (adv && lastPix) state <= IDLE;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pixValid); // R7
endmodule

// File: rtl/line_draw.sv
module line_draw
  import line_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int DELTA_W = 11,
  parameter int COLOR_W = 24,
  parameter int PAT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] startX,
  input  logic [COORD_W-1:0] startY,
  input  logic [DELTA_W-1:0] deltaX,
  input  logic [DELTA_W-1:0] deltaY,
  input  logic               xMajor,
  input  logic               xDec,
  input  logic               yDec,
  input  logic [PAT_W-1:0]   pattern,
  input  logic [$clog2(PAT_W)-1:0] patLast,
  input  logic [COLOR_W-1:0] fgColor,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               bgFill,
  input  logic               pixReady,
  output logic               pixValid,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic [COLOR_W-1:0] pixColor,
  output logic               done
);
  ctlStrobes_t strb;
  logic visible, lastPix;

  line_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .visible(visible),
    .lastPix(lastPix), .pixReady(pixReady), .strb(strb),
    .pixValid(pixValid), .done(done)
  );

  line_dp #(.COORD_W(COORD_W), .DELTA_W(DELTA_W), .COLOR_W(COLOR_W), .PAT_W(PAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startX(startX), .startY(startY),
    .deltaX(deltaX), .deltaY(deltaY), .xMajor(xMajor), .xDec(xDec), .yDec(yDec),
    .pattern(pattern), .patLast(patLast), .fgColor(fgColor), .bgColor(bgColor),
    .bgFill(bgFill), .curX(pixX), .curY(pixY), .color(pixColor),
    .visible(visible), .lastPix(lastPix)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixReady) |=> (pixValid && $stable(pixX) && $stable(pixY) && $stable(pixColor))); // R6
endmodule

// File: tb/tb_line_draw.sv
module tb_line_draw;
  typedef struct packed {
    logic [11:0] sx, sy;
    logic [10:0] dx, dy;
    logic        xMaj, xD, yD;
    logic [15:0] pat;
    logic [3:0]  cnt;
    logic        bg;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{12'd100, 12'd200, 11'd10, 11'd3,  1'b1, 1'b0, 1'b0, 16'hFFFF, 4'hF, 1'b0},
    '{12'd50,  12'd60,  11'd30, 11'd7,  1'b1, 1'b0, 1'b0, 16'h00FF, 4'hF, 1'b0},
    '{12'd50,  12'd60,  11'd30, 11'd7,  1'b1, 1'b1, 1'b0, 16'h00FF, 4'hF, 1'b1},
    '{12'd300, 12'd400, 11'd5,  11'd17, 1'b0, 1'b1, 1'b1, 16'h0005, 4'h2, 1'b1},
    '{12'd7,   12'd9,   11'd0,  11'd0,  1'b1, 1'b0, 1'b0, 16'hFFFF, 4'hF, 1'b0},
    '{12'd7,   12'd9,   11'd0,  11'd0,  1'b0, 1'b0, 1'b0, 16'h0000, 4'hF, 1'b0},
    '{12'd20,  12'd20,  11'd12, 11'd12, 1'b1, 1'b0, 1'b1, 16'h0001, 4'h0, 1'b0}
  };
  localparam logic [23:0] FG = 24'hA1B2C3;
  localparam logic [23:0] BG = 24'h102030;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [11:0] startX = '0, startY = '0;
  logic [10:0] deltaX = '0, deltaY = '0;
  logic xMajor = 1'b1, xDec = 1'b0, yDec = 1'b0, bgFill = 1'b0;
  logic [15:0] pattern = '0;
  logic [3:0] patLast = '0;
  logic pixReady = 1'b0, pixValid, done;
  logic [11:0] pixX, pixY;
  logic [23:0] pixColor;

  always #2 clk = ~clk;

  line_draw dut (
    .clk(clk), .rstN(rstN), .start(start), .startX(startX), .startY(startY),
    .deltaX(deltaX), .deltaY(deltaY), .xMajor(xMajor), .xDec(xDec), .yDec(yDec),
    .pattern(pattern), .patLast(patLast), .fgColor(FG), .bgColor(BG),
    .bgFill(bgFill), .pixReady(pixReady), .pixValid(pixValid), .pixX(pixX),
    .pixY(pixY), .pixColor(pixColor), .done(done)
  );

  int total = 0, bad = 0, cycles = 0;
  int nExp = 0, nGot = 0, doneCnt = 0, expAtDone = 0;
  logic [11:0] expX [64];
  logic [11:0] expY [64];
  logic [23:0] expC [64];
  logic rdyRand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic stalled = 1'b0;
  logic [11:0] hX, hY;
  logic [23:0] hC;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input vec_t v);
    int len, m, e, mj, mn, idx;
    logic on;
    len = v.xMaj ? int'(v.dx) : int'(v.dy);
    m   = v.xMaj ? int'(v.dy) : int'(v.dx);
    e   = 2048 - len / 2;
    mj  = v.xMaj ? int'(v.sx) : int'(v.sy);
    mn  = v.xMaj ? int'(v.sy) : int'(v.sx);
    nExp = 0;
    for (int k = 0; k <= len; k++) begin
      idx = k % (int'(v.cnt) + 1);
      on  = v.pat[idx];
      if (on || v.bg) begin
        expX[nExp] = v.xMaj ? 12'(mj) : 12'(mn);
        expY[nExp] = v.xMaj ? 12'(mn) : 12'(mj);
        expC[nExp] = on ? FG : BG;
        nExp++;
      end
      e += m;
      mj += ((v.xMaj ? v.xD : v.yD) ? -1 : 1);
      if (e >= 2048) begin
        e -= len;
        mn += ((v.xMaj ? v.yD : v.xD) ? -1 : 1);
      end
    end
  endtask

  task automatic applyCfg(input vec_t v);
    startX = v.sx; startY = v.sy; deltaX = v.dx; deltaY = v.dy;
    xMajor = v.xMaj; xDec = v.xD; yDec = v.yD;
    pattern = v.pat; patLast = v.cnt; bgFill = v.bg;
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    while (doneCnt == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R7 done pulse count", doneCnt, 1);
    check(nGot == nExp, "R1 pixel count", nGot, nExp);
    check(expAtDone == nExp, "R7 done after last pixel", expAtDone, nExp);
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rdyRand) pixReady = lfsr[0] | lfsr[2];
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rstN) begin
      if (stalled) begin
        check(pixValid && pixX == hX && pixY == hY && pixColor == hC,
              "R6 hold while stalled", {pixX, pixY}, {hX, hY});
      end
      stalled = pixValid && !pixReady;
      hX = pixX; hY = pixY; hC = pixColor;
      if (pixValid && pixReady) begin
        if (nGot < nExp) begin
          check(pixX == expX[nGot] && pixY == expY[nGot], "R1 R2 R3 R5 pixel position",
                {pixX, pixY}, {expX[nGot], expY[nGot]});
          check(pixColor == expC[nGot], "R4 R5 pixel color", pixColor, expC[nGot]);
        end else begin
          check(1'b0, "R5 extra pixel", nGot, nExp);
        end
        nGot++;
      end
      if (done) begin
        doneCnt++;
        expAtDone = nGot;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(!pixValid, "R9 valid low after reset", pixValid, 0);
    check(!done, "R9 done low after reset", done, 0);

    for (int i = 0; i < NV; i++) begin
      applyCfg(VECS[i]);
      model(VECS[i]);
      nGot = 0; doneCnt = 0; expAtDone = -1;
      rdyRand = (i % 2) == 1;
      if (!rdyRand) pixReady = 1'b1;
      pulseStart();
      waitDone();
    end

    // R8: second start and config change during a stalled line
    rdyRand = 1'b0;
    pixReady = 1'b0;
    applyCfg(VECS[0]);
    model(VECS[0]);
    nGot = 0; doneCnt = 0; expAtDone = -1;
    pulseStart();
    repeat (3) @(posedge clk);
    #1 applyCfg(VECS[3]);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (2) @(posedge clk);
    #1 pixReady = 1'b1;
    waitDone();
    check(nGot == 11, "R8 ignored restart pixel count", nGot, 11);

    // R9: idle after all lines, no stray pixel
    repeat (4) @(negedge clk);
    check(!pixValid && !done, "R9 idle outputs", {pixValid, done}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule